// File: doc/BRIEF.md
# PIO Timing Programming Sequencer

This block runs on the host side of a disk channel. It loads programmed-I/O timing for one drive into a channel controller whose configuration registers open only after a key sequence on its command-block bus. A single start pulse captures the drive's PIO mode, its device number and, when a second drive shares the channel, that drive's mode. The block then probes a strap register to learn the controller's clock speed. It picks the timing bytes for that speed and issues five configuration writes, each inside its own unlock and relock sequence.

The address-setup byte is shared by both drives on a channel. When the second drive is valid, the block therefore uses the larger of the two drives' setup values. The data/recovery byte comes from the target drive alone. All traffic leaves on a simple single-outstanding register-bus master port with a request/ready handshake. A one-cycle done pulse marks the end of the sequence.

Top module: `pio_prog_seq`

## Requirements
- R1: After reset `bus_req_o` and `done_o` are low. While idle with no start, no bus request is raised.
- R2: The first transaction after an accepted start is a byte write of 0xFF to offset 5. The second is a 16-bit read of offset 5. Bit 0 of that read data selects the clock table (0 = slow, 1 = fast), and all other read bits are ignored.
- R3: Setup bytes for modes 0,1,2,3,4 are 30,20,20,10,10 (hex) with the slow clock and 20,20,10,10,10 with the fast clock. Data/recovery bytes are 6B,56,42,32,31 (slow) and 58,44,32,22,21 (fast).
- R4: When `pair_valid_i` is high at start, the setup byte written is the larger of the two drives' table values. When it is low, `pair_mode_i` has no effect.
- R5: A mode input above 4 (for either drive) is treated as mode 4.
- R6: The five configuration writes go out in this order: offset 6 ← device number (zero-extended), offset 0 ← data/recovery byte, offset 1 ← the same byte, offset 6 ← setup byte, offset 3 ← 0x85.
- R7: Each configuration write is preceded by two 16-bit reads of offset 1 and a byte write of 0x03 to offset 2. It is followed by a byte write of 0x83 to offset 2. A full run is 27 transactions.
- R8: A transaction completes on a rising edge where `bus_req_o` and `bus_ready_i` are both high. Until then, request, direction, width, offset and write data are held unchanged. Reads are 16-bit (`bus_wide_o`=1) and writes are bytes (`bus_wide_o`=0).
- R9: `done_o` is high for exactly the one cycle that follows the edge completing the final relock write. `bus_req_o` is low in that cycle.
- R10: Inputs are captured only on an accepted start. A start pulse or an input change during a run has no effect on the traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the mode inputs |
| mode_i | input | 3 | PIO mode of the drive being programmed |
| devno_i | input | 1 | Device number of that drive |
| pair_valid_i | input | 1 | Second drive present on the channel |
| pair_mode_i | input | 3 | PIO mode of the second drive |
| bus_req_o | output | 1 | Transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_wide_o | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr_o | output | 3 | Register offset |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with ready on reads |
| bus_ready_i | input | 1 | Slave completes the request at this edge |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first request appears in the cycle after the edge that accepts start. Each later request appears in the cycle after the previous handshake edge, and `done_o` follows the last handshake edge by exactly one cycle. The bench's slave model logs each transaction at the falling edge where it raises ready, so the logged fields are the ones present at the completing rising edge. It stamps done against the cycle of the final log, and done must land at exactly log cycle + 1. Runs with zero and two cycles of slave latency show that the one-cycle relation holds however long each transaction waits.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int OFS_W  = 3;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int MSEL_W = 3;

  localparam logic [OFS_W-1:0] OFS_RD_TIM = 3'd0;
  localparam logic [OFS_W-1:0] OFS_WR_TIM = 3'd1;
  localparam logic [OFS_W-1:0] OFS_GATE   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_KEY    = 3'd2;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd3;
  localparam logic [OFS_W-1:0] OFS_STRAP  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MISC   = 3'd6;

  localparam logic [BYTE_W-1:0] KEY_OPEN    = 8'h03;
  localparam logic [BYTE_W-1:0] KEY_CLOSE   = 8'h83;
  localparam logic [BYTE_W-1:0] CTRL_FINAL  = 8'h85;
  localparam logic [BYTE_W-1:0] STRAP_PROBE = 8'hFF;

  typedef struct packed {
    logic              we;
    logic              wide;
    logic [OFS_W-1:0]  ofs;
    logic [BYTE_W-1:0] data;
  } bus_op_t;

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_CFG, S_FIN} seq_state_t;

  function automatic logic [BYTE_W-1:0] setup_byte(input logic fast, input logic [MSEL_W-1:0] m);
    logic [BYTE_W-1:0] v;
    case (m)
      3'd0:    v = fast ? 8'h20 : 8'h30;
      3'd1:    v = 8'h20;
      3'd2:    v = fast ? 8'h10 : 8'h20;
      default: v = 8'h10;
    endcase
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] drec_byte(input logic fast, input logic [MSEL_W-1:0] m);
    logic [BYTE_W-1:0] v;
    case (m)
      3'd0:    v = fast ? 8'h58 : 8'h6B;
      3'd1:    v = fast ? 8'h44 : 8'h56;
      3'd2:    v = fast ? 8'h32 : 8'h42;
      3'd3:    v = fast ? 8'h22 : 8'h32;
      default: v = fast ? 8'h21 : 8'h31;
    endcase
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] max_byte(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic bus_op_t mk_op(input logic we, input logic [OFS_W-1:0] ofs, input logic [BYTE_W-1:0] d);
    bus_op_t o;
    o.we   = we;
    o.wide = ~we;
    o.ofs  = ofs;
    o.data = d;
    return o;
  endfunction
endpackage

// File: rtl/pio_mode_clamp.sv
module pio_mode_clamp
  import pio_seq_pkg::*;
#(
  parameter int MODE_W   = 3,
  parameter int MAX_MODE = 4
) (
  input  logic [MODE_W-1:0] mode_in,
  output logic [MSEL_W-1:0] mode_out
);
  localparam logic [MODE_W-1:0] LIMIT = MODE_W'(MAX_MODE);

  always_comb begin
    if (mode_in > LIMIT) mode_out = MSEL_W'(LIMIT);
    else                 mode_out = MSEL_W'(mode_in);
  end
endmodule

// File: rtl/pio_timing_lut.sv
module pio_timing_lut
  import pio_seq_pkg::*;
(
  input  logic              fast,
  input  logic [MSEL_W-1:0] mode_a,
  input  logic [MSEL_W-1:0] mode_b,
  input  logic              pair_ok,
  output logic [BYTE_W-1:0] setup_val,
  output logic [BYTE_W-1:0] drec_val
);
  logic [BYTE_W-1:0] setup_a, setup_b;

  always_comb begin
    setup_a   = setup_byte(fast, mode_a);
    setup_b   = setup_byte(fast, mode_b);
    setup_val = pair_ok ? max_byte(setup_a, setup_b) : setup_a;
    drec_val  = drec_byte(fast, mode_a);
  end
endmodule

// File: rtl/pio_step_decode.sv
module pio_step_decode
  import pio_seq_pkg::*;
#(
  parameter int DEV_W = 1
) (
  input  logic              in_probe,
  input  logic              probe_idx,
  input  logic [2:0]        cfg_idx,
  input  logic [2:0]        sub_idx,
  input  logic [DEV_W-1:0]  devno,
  input  logic [BYTE_W-1:0] drec_val,
  input  logic [BYTE_W-1:0] setup_val,
  output bus_op_t           op
);
  logic [OFS_W-1:0]  tgt_ofs;
  logic [BYTE_W-1:0] tgt_data;

  always_comb begin
    case (cfg_idx)
      3'd0:    begin tgt_ofs = OFS_MISC;   tgt_data = BYTE_W'(devno); end
      3'd1:    begin tgt_ofs = OFS_RD_TIM; tgt_data = drec_val;       end
      3'd2:    begin tgt_ofs = OFS_WR_TIM; tgt_data = drec_val;       end
      3'd3:    begin tgt_ofs = OFS_MISC;   tgt_data = setup_val;      end
      default: begin tgt_ofs = OFS_CTRL;   tgt_data = CTRL_FINAL;     end
    endcase

    if (in_probe) begin
      op = probe_idx ? mk_op(1'b0, OFS_STRAP, '0) : mk_op(1'b1, OFS_STRAP, STRAP_PROBE);
    end else begin
      case (sub_idx)
        3'd0, 3'd1: op = mk_op(1'b0, OFS_GATE, '0);
        3'd2:       op = mk_op(1'b1, OFS_KEY, KEY_OPEN);
        3'd3:       op = mk_op(1'b1, tgt_ofs, tgt_data);
        default:    op = mk_op(1'b1, OFS_KEY, KEY_CLOSE);
      endcase
    end
  end
endmodule

// File: rtl/pio_prog_seq.sv
module pio_prog_seq
  import pio_seq_pkg::*;
#(
  parameter int MODE_W   = 3,
  parameter int MAX_MODE = 4,
  parameter int DEV_W    = 1,
  parameter int NUM_CFG  = 5,
  parameter int SUB_STEPS = 5,
  parameter int STRAP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DEV_W-1:0]  devno_i,
  input  logic              pair_valid_i,
  input  logic [MODE_W-1:0] pair_mode_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_wide_o,
  output logic [OFS_W-1:0]  bus_addr_o,
  output logic [BYTE_W-1:0] bus_wdata_o,
  input  logic [WORD_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i,
  output logic              done_o
);
  localparam logic [2:0] LAST_CFG = 3'(NUM_CFG - 1);
  localparam logic [2:0] LAST_SUB = 3'(SUB_STEPS - 1);

  seq_state_t        state_q;
  logic              probe_idx_q;
  logic [2:0]        cfg_idx_q, sub_idx_q;
  logic              fast_q;
  logic [MODE_W-1:0] mode_q, pair_mode_q;
  logic              pair_ok_q;
  logic [DEV_W-1:0]  devno_q;

  logic [MSEL_W-1:0] mode_a_c, mode_b_c;
  logic [BYTE_W-1:0] setup_val, drec_val;
  bus_op_t           op;

  // named events used by the checker
  logic xfer_w, last_xfer_w, accept_w;
  logic unused_rdata;

  assign unused_rdata = ^bus_rdata_i;
  assign bus_req_o   = (state_q == S_PROBE) || (state_q == S_CFG);
  assign done_o      = (state_q == S_FIN);
  assign xfer_w      = bus_req_o && bus_ready_i;
  assign accept_w    = start_i && (state_q == S_IDLE);
  assign last_xfer_w = xfer_w && (state_q == S_CFG) &&
                       (cfg_idx_q == LAST_CFG) && (sub_idx_q == LAST_SUB);

  pio_mode_clamp #(.MODE_W(MODE_W), .MAX_MODE(MAX_MODE)) u_clamp_a (
    .mode_in(mode_q), .mode_out(mode_a_c));
  pio_mode_clamp #(.MODE_W(MODE_W), .MAX_MODE(MAX_MODE)) u_clamp_b (
    .mode_in(pair_mode_q), .mode_out(mode_b_c));

  pio_timing_lut u_lut (
    .fast(fast_q), .mode_a(mode_a_c), .mode_b(mode_b_c), .pair_ok(pair_ok_q),
    .setup_val(setup_val), .drec_val(drec_val));

  pio_step_decode #(.DEV_W(DEV_W)) u_dec (
    .in_probe(state_q == S_PROBE), .probe_idx(probe_idx_q),
    .cfg_idx(cfg_idx_q), .sub_idx(sub_idx_q), .devno(devno_q),
    .drec_val(drec_val), .setup_val(setup_val), .op(op));

  assign bus_we_o    = op.we;
  assign bus_wide_o  = op.wide;
  assign bus_addr_o  = op.ofs;
  assign bus_wdata_o = op.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      probe_idx_q <= 1'b0;
      cfg_idx_q   <= '0;
      sub_idx_q   <= '0;
      fast_q      <= 1'b0;
      mode_q      <= '0;
      pair_mode_q <= '0;
      pair_ok_q   <= 1'b0;
      devno_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept_w) begin
          mode_q      <= mode_i;
          pair_mode_q <= pair_mode_i;
          pair_ok_q   <= pair_valid_i;
          devno_q     <= devno_i;
          probe_idx_q <= 1'b0;
          state_q     <= S_PROBE;
        end
        S_PROBE: if (xfer_w) begin
          if (!probe_idx_q) begin
            probe_idx_q <= 1'b1;
          end else begin
            fast_q    <= bus_rdata_i[STRAP_BIT];
            cfg_idx_q <= '0;
            sub_idx_q <= '0;
            state_q   <= S_CFG;
          end
        end
        S_CFG: if (xfer_w) begin
          if (sub_idx_q == LAST_SUB) begin
            sub_idx_q <= '0;
            if (cfg_idx_q == LAST_CFG) state_q <= S_FIN;
            else cfg_idx_q <= cfg_idx_q + 3'd1;
          end else begin
            sub_idx_q <= sub_idx_q + 3'd1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_prog_seq_chk.sv
module pio_prog_seq_chk
  import pio_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic              bus_wide_o,
  input logic [OFS_W-1:0]  bus_addr_o,
  input logic [BYTE_W-1:0] bus_wdata_o,
  input logic              bus_ready_i,
  input logic              done_o,
  input logic              last_xfer_w
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_wide_o)
                                     && $stable(bus_addr_o) && $stable(bus_wdata_o)));
  // R8
  read_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_wide_o == !bus_we_o));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!bus_req_o && $past(last_xfer_w)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_o && !done_o && !start_i) |=> !bus_req_o);
  // R2
  first_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !bus_req_o && !done_o) |=> (bus_req_o && bus_we_o
                                            && bus_addr_o == OFS_STRAP && bus_wdata_o == STRAP_PROBE));
endmodule

bind pio_prog_seq pio_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o), .bus_wide_o(bus_wide_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i), .done_o(done_o),
  .last_xfer_w(last_xfer_w));

// File: tb/pio_prog_seq_tb.sv
module pio_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTX = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] mode_i = '0, pair_mode_i = '0;
  logic devno_i = 1'b0, pair_valid_i = 1'b0;
  logic bus_req_o, bus_we_o, bus_wide_o, done_o;
  logic [2:0] bus_addr_o;
  logic [7:0] bus_wdata_o;
  logic [15:0] bus_rdata_i = '0;
  logic bus_ready_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .devno_i(devno_i),
    .pair_valid_i(pair_valid_i), .pair_mode_i(pair_mode_i), .bus_req_o(bus_req_o),
    .bus_we_o(bus_we_o), .bus_wide_o(bus_wide_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i),
    .done_o(done_o));

  int n_chk = 0, n_fail = 0;
  int cyc = 0, lat = 0, wcnt = 0;
  int log_n = 0, log_cyc = 0, done_cnt = 0, done_cyc = 0, hold_err = 0;
  logic [15:0] strap_word = '0;
  logic lg_we[32], lg_wide[32];
  logic [2:0] lg_addr[32];
  logic [7:0] lg_data[32];
  logic [12:0] prev_op;
  logic prev_wait = 1'b0;

  // slave model: decides ready and logs at falling edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done_o) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
    if (bus_req_o) begin
      if (prev_wait && prev_op != {bus_we_o, bus_wide_o, bus_addr_o, bus_wdata_o}) hold_err = hold_err + 1;
      bus_rdata_i <= (bus_addr_o == 3'd5) ? strap_word : 16'hABCD;
      if (wcnt >= lat) begin
        bus_ready_i <= 1'b1;
        if (log_n < 32) begin
          lg_we[log_n] = bus_we_o; lg_wide[log_n] = bus_wide_o;
          lg_addr[log_n] = bus_addr_o; lg_data[log_n] = bus_wdata_o;
        end
        log_n = log_n + 1;
        log_cyc = cyc;
        wcnt = 0;
        prev_wait = 1'b0;
      end else begin
        bus_ready_i <= 1'b0;
        wcnt = wcnt + 1;
        prev_wait = 1'b1;
        prev_op = {bus_we_o, bus_wide_o, bus_addr_o, bus_wdata_o};
      end
    end else begin
      bus_ready_i <= 1'b0;
      wcnt = 0;
      prev_wait = 1'b0;
    end
  end

  function automatic int sat(input int m);
    return (m > 4) ? 4 : m;
  endfunction

  function automatic logic [7:0] tb_setup(input int fast, input int m);
    logic [7:0] t [10] = '{8'h30, 8'h20, 8'h20, 8'h10, 8'h10, 8'h20, 8'h20, 8'h10, 8'h10, 8'h10};
    return t[fast*5 + sat(m)];
  endfunction

  function automatic logic [7:0] tb_drec(input int fast, input int m);
    logic [7:0] t [10] = '{8'h6B, 8'h56, 8'h42, 8'h32, 8'h31, 8'h58, 8'h44, 8'h32, 8'h22, 8'h21};
    return t[fast*5 + sat(m)];
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input int m, input int dv, input int pv, input int pm);
    @(negedge clk);
    mode_i = 3'(m); devno_i = dv[0]; pair_valid_i = pv[0]; pair_mode_i = 3'(pm);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one full programming run and its checks
  task automatic run_seq(input string tag, input int m, input int dv, input int pv, input int pm,
                         input logic [15:0] sw, input int l, input bit disturb);
    logic ew[NTX], ewide[NTX];
    logic [2:0] ea[NTX];
    logic [7:0] ed[NTX];
    int fast, su, k;
    logic [2:0] tofs[5];
    logic [7:0] tdat[5];
    strap_word = sw; lat = l;
    log_n = 0; done_cnt = 0; hold_err = 0;
    fast = sw[0];
    su = tb_setup(fast, m);
    if (pv != 0 && tb_setup(fast, pm) > su) su = tb_setup(fast, pm);
    tofs = '{3'd6, 3'd0, 3'd1, 3'd6, 3'd3};
    tdat = '{8'(dv), tb_drec(fast, m), tb_drec(fast, m), 8'(su), 8'h85};
    ew[0] = 1; ewide[0] = 0; ea[0] = 3'd5; ed[0] = 8'hFF;
    ew[1] = 0; ewide[1] = 1; ea[1] = 3'd5; ed[1] = 8'h00;
    for (int c = 0; c < 5; c++) begin
      k = 2 + 5*c;
      ew[k] = 0;   ewide[k] = 1;   ea[k] = 3'd1;   ed[k] = 0;
      ew[k+1] = 0; ewide[k+1] = 1; ea[k+1] = 3'd1; ed[k+1] = 0;
      ew[k+2] = 1; ewide[k+2] = 0; ea[k+2] = 3'd2; ed[k+2] = 8'h03;
      ew[k+3] = 1; ewide[k+3] = 0; ea[k+3] = tofs[c]; ed[k+3] = tdat[c];
      ew[k+4] = 1; ewide[k+4] = 0; ea[k+4] = 3'd2; ed[k+4] = 8'h83;
    end
    pulse_start(m, dv, pv, pm);
    if (disturb) begin
      // R10: restart attempt and input change mid-run
      repeat (8) @(negedge clk);
      pulse_start(sat(m) ^ 3, dv ^ 1, pv ^ 1, 0);
      mode_i = 3'd0; devno_i = ~devno_i;
    end
    for (int w = 0; w < 2000 && done_cnt == 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(log_n == NTX, "R7", {tag, " transaction count"}, log_n, NTX);
    for (int i = 0; i < NTX && i < log_n; i++) begin
      bit ok;
      string rq;
      ok = (lg_we[i] == ew[i]) && (lg_wide[i] == ewide[i]) && (lg_addr[i] == ea[i]) &&
           (!ew[i] || lg_data[i] == ed[i]);
      rq = (i < 2) ? "R2" : (((i - 2) % 5 == 3) ? tag : "R7/R8");
      check(ok, rq, $sformatf("txn %0d {we,wide,ofs,data}", i),
            {lg_we[i], lg_wide[i], lg_addr[i], lg_data[i]}, {ew[i], ewide[i], ea[i], ed[i]});
    end
    check(done_cnt == 1, "R9", {tag, " done pulse count"}, done_cnt, 1);
    check(done_cyc == log_cyc + 1, "R9", {tag, " done cycle after last handshake"}, done_cyc - log_cyc, 1);
    check(hold_err == 0, "R8", {tag, " request held while waiting"}, hold_err, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_req_o == 0, "R1", "req after reset", bus_req_o, 0);
    check(done_o == 0, "R1", "done after reset", done_o, 0);
    repeat (5) @(negedge clk);
    check(log_n == 0, "R1", "no traffic while idle", log_n, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail = n_fail + 1; n_chk = n_chk + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    run_seq("R3", 0, 0, 0, 0, 16'h0000, 0, 0);   // slow clock, mode 0
    run_seq("R3", 4, 0, 0, 0, 16'h0001, 2, 0);   // fast clock, mode 4, slow slave
    run_seq("R6", 2, 1, 0, 0, 16'hFFFF, 1, 0);   // device 1, fast clock
    run_seq("R4", 3, 0, 1, 0, 16'h0000, 0, 0);   // pair setup dominates
    run_seq("R4", 0, 0, 0, 4, 16'h0000, 0, 0);   // pair ignored when not valid
    run_seq("R5", 7, 1, 1, 6, 16'h0000, 0, 0);   // both modes saturate
    run_seq("R2", 1, 0, 0, 0, 16'hFFFE, 1, 0);   // only bit 0 of strap matters
    run_seq("R10", 2, 0, 1, 0, 16'h0000, 1, 1);  // restart ignored mid-run
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule